// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This block feeds a transmit MAC from a circular list of buffer descriptors kept in system memory. When software sets the kick strobe, the engine reads a descriptor (two 32-bit words), checks the ownership flag, and streams the referenced buffer one byte at a time toward the MAC. The byte stream carries an end-of-frame marker and the checksum mode that the MAC should apply. The engine then rewrites the first descriptor word with ownership returned to software and moves on to the next entry.

A single request/acknowledge memory port serves descriptor reads, buffer reads and descriptor write-back. The next descriptor either follows the current one in memory or, when the entry carries a wrap flag, is taken from the ring base input. The engine reports a finished frame and each abort through one-cycle interrupt pulses. No status is written into memory.

Top module: `txd_ring_dma`

## Requirements
- R1: After reset, `mem_req`, `tx_valid`, `irq_frame` and `irq_err` are low. The first kick after reset fetches the descriptor at `ring_base`. Later kicks resume at the engine's current descriptor address.
- R2: A descriptor is word 0 at address A and word 1 at A+4. Word 0 holds: bit 31 ready, bit 29 wrap, bit 27 last, bit 26 checksum enable, bit 25 bad checksum, bits 15:0 byte length. Bits 30 and 28 belong to software. Word 1 is the byte address of the buffer.
- R3: A fetched word 0 with bit 31 = 0 stops the engine at that address, with no byte output and no memory write. The next kick fetches the same address again.
- R4: The buffer bytes are sent in order, starting at the pointer, exactly `length` of them, at any byte alignment. The byte at address a is bits [31-8*(a mod 4) -: 8] of the word at a with its two low bits cleared.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_eof` and `tx_crc` hold.
- R6: `tx_eof` is high only on the final byte of a descriptor whose last flag is set. `tx_crc` is 0 on every byte without `tx_eof`. On an end byte it is 2 when bad checksum is set, otherwise 1 when checksum enable is set, otherwise 0. On descriptors without the last flag, both checksum flags are ignored.
- R7: The write-back is a single write of word 0 to address A. Bit 31 is cleared and all other bits keep their fetched values, including software bits 30 and 28.
- R8: After a write-back, the next descriptor is at `ring_base` if the wrap flag was set, otherwise at A+8. It is fetched without a further kick.
- R9: `irq_frame` pulses for exactly one cycle, in the cycle after the write-back of a last-flagged descriptor is acknowledged. No pulse follows a descriptor without the last flag.
- R10: A zero length, or an error response on a buffer read, aborts the descriptor. No further bytes are sent, the write-back still clears bit 31, `irq_err` pulses once, and the engine advances as in R8.
- R11: An error response on either descriptor word read pulses `irq_err` and stops the engine at that descriptor, with no write-back. The next kick fetches it again.
- R12: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we` and `mem_addr` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | AW | Byte address of the first descriptor in the ring |
| kick | input | 1 | One-cycle strobe: descriptors are ready |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data (descriptor word 0) |
| mem_ack | input | 1 | Access completed this cycle |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| tx_valid | output | 1 | Byte available |
| tx_ready | input | 1 | MAC accepts the byte |
| tx_data | output | 8 | Byte to transmit |
| tx_eof | output | 1 | Final byte of the frame |
| tx_crc | output | 2 | Checksum mode on the final byte: 0 none, 1 normal, 2 inverted |
| irq_frame | output | 1 | Frame-complete pulse |
| irq_err | output | 1 | Error pulse |

## Verification
A wrong byte-lane or pointer state shows up within one handshake as a wrong `tx_data` value. A length counter that is off by one moves `tx_eof` and `tx_crc` to the wrong byte, or changes the number of bytes, before the descriptor ends. A wrong ring address shows up at the next descriptor fetch as a read from an unexpected location, and then as memory words whose ready bit is never cleared. A wrong write-back or flag decode becomes visible in memory as soon as the write is acknowledged, and in `irq_frame` or `irq_err` one cycle later.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int DW         = 32;
  localparam int LEN_W      = 16;
  localparam int DESC_BYTES = 8;
  localparam int NLANE      = DW / 8;
  localparam int LANE_W     = $clog2(NLANE);

  localparam int F_READY = 31;
  localparam int F_WRAP  = 29;
  localparam int F_LAST  = 27;
  localparam int F_CKSUM = 26;
  localparam int F_BADCK = 25;

  typedef enum logic [2:0] {
    S_IDLE, S_DESC0, S_DESC1, S_LOAD, S_SEND, S_WBACK
  } txd_state_e;

  typedef enum logic [1:0] {
    CK_NONE = 2'd0,
    CK_GOOD = 2'd1,
    CK_INV  = 2'd2
  } ck_mode_e;

  function automatic ck_mode_e pick_ck(input logic good, input logic bad);
    if (bad)       return CK_INV;
    else if (good) return CK_GOOD;
    else           return CK_NONE;
  endfunction
endpackage

// File: rtl/txd_byte_sel.sv
module txd_byte_sel #(
  parameter int WW = 32,
  localparam int NB = WW / 8,
  localparam int LW = $clog2(NB)
) (
  input  logic [WW-1:0] word,
  input  logic [LW-1:0] lane,
  output logic [7:0]    lane_byte
);
  logic [7:0] lanes [NB];

  // big-endian: lane 0 is the most significant byte
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lanes[g] = word[WW-1-8*g -: 8];
  end

  assign lane_byte = lanes[lane];
endmodule

// File: rtl/txd_ring_ptr.sv
module txd_ring_ptr #(
  parameter int AW     = 32,
  parameter int STRIDE = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ring_base,
  input  logic          start,
  input  logic          advance,
  input  logic          wrap,
  output logic [AW-1:0] cur_addr
);
  logic have_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      have_ptr <= 1'b0;
    end else if (start && !have_ptr) begin
      cur_addr <= ring_base;
      have_ptr <= 1'b1;
    end else if (advance) begin
      cur_addr <= wrap ? ring_base : cur_addr + AW'(STRIDE);
    end
  end
endmodule

// File: rtl/txd_ring_dma.sv
module txd_ring_dma
  import txd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ring_base,
  input  logic          kick,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_eof,
  output logic [1:0]    tx_crc,
  output logic          irq_frame,
  output logic          irq_err
);
  txd_state_e        state;
  logic [DW-1:0]     w0;
  logic [AW-1:0]     ptr;
  logic [LEN_W-1:0]  remain;
  logic [DW-1:0]     dword;
  logic              abort;
  logic [AW-1:0]     cur_addr;
  logic              wb_done;
  logic              is_end;

  assign wb_done = (state == S_WBACK) && mem_ack;
  assign is_end  = (remain == LEN_W'(1));

  txd_ring_ptr #(.AW(AW), .STRIDE(DESC_BYTES)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .ring_base (ring_base),
    .start     ((state == S_IDLE) && kick),
    .advance   (wb_done),
    .wrap      (w0[F_WRAP]),
    .cur_addr  (cur_addr)
  );

  txd_byte_sel #(.WW(DW)) u_sel (
    .word      (dword),
    .lane      (ptr[LANE_W-1:0]),
    .lane_byte (tx_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      w0        <= '0;
      ptr       <= '0;
      remain    <= '0;
      dword     <= '0;
      abort     <= 1'b0;
      irq_frame <= 1'b0;
      irq_err   <= 1'b0;
    end else begin
      irq_frame <= 1'b0;
      irq_err   <= 1'b0;
      unique case (state)
        S_IDLE: if (kick) state <= S_DESC0;
        S_DESC0: if (mem_ack) begin
          if (mem_err) begin
            irq_err <= 1'b1;
            state   <= S_IDLE;
          end else if (!mem_rdata[F_READY]) begin
            state <= S_IDLE;
          end else begin
            w0    <= mem_rdata;
            state <= S_DESC1;
          end
        end
        S_DESC1: if (mem_ack) begin
          if (mem_err) begin
            irq_err <= 1'b1;
            state   <= S_IDLE;
          end else begin
            ptr    <= mem_rdata[AW-1:0];
            remain <= w0[LEN_W-1:0];
            if (w0[LEN_W-1:0] == '0) begin
              abort <= 1'b1;
              state <= S_WBACK;
            end else begin
              abort <= 1'b0;
              state <= S_LOAD;
            end
          end
        end
        S_LOAD: if (mem_ack) begin
          if (mem_err) begin
            abort <= 1'b1;
            state <= S_WBACK;
          end else begin
            dword <= mem_rdata;
            state <= S_SEND;
          end
        end
        S_SEND: if (tx_ready) begin
          ptr    <= ptr + AW'(1);
          remain <= remain - LEN_W'(1);
          if (is_end)
            state <= S_WBACK;
          else if (&ptr[LANE_W-1:0])
            state <= S_LOAD;
        end
        S_WBACK: if (mem_ack) begin
          if (abort)
            irq_err <= 1'b1;
          else if (w0[F_LAST])
            irq_frame <= 1'b1;
          state <= S_DESC0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = cur_addr;
    unique case (state)
      S_DESC0: mem_req = 1'b1;
      S_DESC1: begin
        mem_req  = 1'b1;
        mem_addr = cur_addr + AW'(4);
      end
      S_LOAD: begin
        mem_req  = 1'b1;
        mem_addr = {ptr[AW-1:LANE_W], {LANE_W{1'b0}}};
      end
      S_WBACK: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    mem_wdata          = w0;
    mem_wdata[F_READY] = 1'b0;
  end

  assign tx_valid = (state == S_SEND);
  assign tx_eof   = tx_valid && is_end && w0[F_LAST];
  assign tx_crc   = tx_eof ? pick_ck(w0[F_CKSUM], w0[F_BADCK]) : CK_NONE;
endmodule

// File: rtl/txd_chk.sv
module txd_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_eof,
  input logic [1:0]    tx_crc,
  input logic          irq_frame,
  input logic          irq_err
);
  a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  a_r5_tx_hold: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_eof) && $stable(tx_crc));

  a_r9_frame_after_wb: assert property (@(posedge clk) disable iff (rst)
    irq_frame |-> $past(mem_req && mem_we && mem_ack));

  a_r9_frame_pulse: assert property (@(posedge clk) disable iff (rst)
    irq_frame |=> !irq_frame);

  a_r10_irq_excl: assert property (@(posedge clk) disable iff (rst)
    !(irq_frame && irq_err));

  a_r6_eof_valid: assert property (@(posedge clk) disable iff (rst)
    tx_eof |-> tx_valid);

  a_r6_no_tx_during_mem: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !mem_req);
endmodule

bind txd_ring_dma txd_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .tx_eof    (tx_eof),
  .tx_crc    (tx_crc),
  .irq_frame (irq_frame),
  .irq_err   (irq_err)
);

// File: tb/test_txd_ring_dma.sv
`timescale 1ns/1ps
module test_txd_ring_dma;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ring_base = '0;
  logic        kick = 1'b0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        tx_eof;
  logic [1:0]  tx_crc;
  logic        irq_frame, irq_err;

  always #2.5 clk = ~clk;

  txd_ring_dma #(.AW(32)) i_txd_ring_dma (
    .clk(clk), .rst(rst), .ring_base(ring_base), .kick(kick),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_eof(tx_eof),
    .tx_crc(tx_crc), .irq_frame(irq_frame), .irq_err(irq_err)
  );

  logic [31:0] mem [0:255];
  int checks = 0, errors = 0, cyc = 0;
  int n = 0, frm_cnt = 0, err_cnt = 0, wb_cnt = 0;
  int frm_cyc = 0, last_wb_cyc = 0;
  logic [31:0] last_rd = '0;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;
  int          bp_mode = 0;
  logic [7:0]  got_d [0:63];
  logic        got_e [0:63];
  logic [1:0]  got_c [0:63];

  function automatic logic [7:0] byte_at(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  // memory responder and stream monitor, away from the active edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mem_ack) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end else if (mem_req && !rst) begin
      mem_ack = 1'b1;
      mem_err = err_en && (mem_addr == err_addr);
      if (mem_we) begin
        if (!mem_err) mem[mem_addr[9:2]] = mem_wdata;
        wb_cnt = wb_cnt + 1;
        last_wb_cyc = cyc;
      end else begin
        mem_rdata = mem[mem_addr[9:2]];
        last_rd = mem_addr;
      end
    end
    tx_ready = (bp_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    if (tx_valid && tx_ready && !rst) begin
      if (n < 64) begin
        got_d[n] = tx_data; got_e[n] = tx_eof; got_c[n] = tx_crc;
      end
      n = n + 1;
    end
    if (irq_frame && !rst) begin frm_cnt = frm_cnt + 1; frm_cyc = cyc; end
    if (irq_err && !rst) err_cnt = err_cnt + 1;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr;
    n = 0; frm_cnt = 0; err_cnt = 0; wb_cnt = 0;
  endtask

  task automatic do_reset(input logic [31:0] base);
    @(negedge clk);
    rst = 1'b1; ring_base = base; err_en = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    clr();
  endtask

  task automatic put_desc(input int a, input logic [15:0] fl, input logic [15:0] len, input logic [31:0] p);
    mem[a >> 2]       = {fl, len};
    mem[(a >> 2) + 1] = p;
  endtask

  task automatic do_kick;
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
  endtask

  task automatic settle(input int want_frm, input int lim);
    for (int k = 0; k < lim && frm_cnt < want_frm; k++) @(negedge clk);
    repeat (30) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++)
      mem[i] = {byte_at(4*i), byte_at(4*i+1), byte_at(4*i+2), byte_at(4*i+3)};

    // R1: reset state
    do_reset(32'h0);
    @(negedge clk);
    check(!mem_req && !tx_valid && !irq_frame && !irq_err, "R1 reset outputs",
          {mem_req, tx_valid, irq_frame, irq_err}, 0);

    // R2 R4 R6 R7 R9: sweep length 1..9 and all four alignments, ring of one wrapping entry
    for (int len = 1; len <= 9; len++) begin
      for (int off = 0; off < 4; off++) begin
        logic [15:0] fl;
        logic [31:0] p;
        logic ok_d, ok_e;
        fl = 16'h8000 | 16'h2000 | 16'h0800 | 16'h0400;
        if ((len + off) % 2 == 1) fl = fl | 16'h4000;
        if (off % 2 == 1)         fl = fl | 16'h1000;
        p = 32'h100 + 32'(len * 8) + 32'(off);
        put_desc(0, fl, 16'(len), p);
        bp_mode = (len + off) % 2;
        clr();
        do_kick();
        settle(1, 400);
        check(n == len, "R4 byte count", n, len);
        ok_d = 1'b1; ok_e = 1'b1;
        for (int i = 0; i < len && i < 64; i++) begin
          if (got_d[i] != byte_at(int'(p) + i)) ok_d = 1'b0;
          if (got_e[i] != (i == len - 1)) ok_e = 1'b0;
          if (i < len - 1 && got_c[i] != 2'd0) ok_e = 1'b0;
        end
        check(ok_d, "R4 big-endian bytes", len, off);
        check(ok_e && got_c[len-1] == 2'd1, "R6 eof and normal checksum", got_c[len-1], 1);
        check(mem[0] == ({fl, 16'(len)} & 32'h7FFF_FFFF), "R7 write-back word",
              mem[0], {fl, 16'(len)} & 32'h7FFF_FFFF);
        check(wb_cnt == 1 && frm_cnt == 1 && frm_cyc - last_wb_cyc == 1, "R9 frame pulse timing",
              frm_cyc - last_wb_cyc, 1);
      end
    end
    bp_mode = 0;

    // R6 R8: three-buffer frame, consecutive entries then wrap, inverted checksum
    do_reset(32'h40);
    put_desc(32'h40, 16'h8600, 16'd3, 32'h200);
    put_desc(32'h48, 16'h8600, 16'd2, 32'h301);
    put_desc(32'h50, 16'hAA00, 16'd4, 32'h2A2);
    do_kick();
    settle(1, 600);
    begin
      logic ok_d, ok_e;
      int exp_a [0:8];
      for (int i = 0; i < 3; i++) exp_a[i]     = 32'h200 + i;
      for (int i = 0; i < 2; i++) exp_a[3 + i] = 32'h301 + i;
      for (int i = 0; i < 4; i++) exp_a[5 + i] = 32'h2A2 + i;
      ok_d = 1'b1; ok_e = 1'b1;
      for (int i = 0; i < 9; i++) begin
        if (got_d[i] != byte_at(exp_a[i])) ok_d = 1'b0;
        if (got_e[i] != (i == 8)) ok_e = 1'b0;
        if (i < 8 && got_c[i] != 2'd0) ok_e = 1'b0;
      end
      check(n == 9 && ok_d, "R4 multi-buffer bytes", n, 9);
      check(ok_e && got_c[8] == 2'd2, "R6 inverted checksum, middle flags ignored", got_c[8], 2);
    end
    check(frm_cnt == 1, "R9 one pulse per frame", frm_cnt, 1);
    check(!mem[16][31] && !mem[18][31] && !mem[20][31], "R8 consecutive entries released",
          {mem[16][31], mem[18][31], mem[20][31]}, 0);
    check(last_rd == 32'h40, "R8 wrap to ring base", last_rd, 32'h40);

    // R3: refetch after re-arm
    clr();
    put_desc(32'h40, 16'hA800, 16'd1, 32'h240);
    do_kick();
    settle(1, 200);
    check(n == 1 && got_d[0] == byte_at(32'h240) && frm_cnt == 1, "R3 refetch same address", n, 1);

    // R3 R1: not-ready entry stops the engine
    do_reset(32'h80);
    put_desc(32'h80, 16'h2800, 16'd2, 32'h280);
    do_kick();
    repeat (40) @(negedge clk);
    check(n == 0 && wb_cnt == 0, "R3 no output, no write", n + wb_cnt, 0);
    check(last_rd == 32'h80, "R1 first fetch at ring base", last_rd, 32'h80);
    mem[32] = mem[32] | 32'h8000_0000;
    do_kick();
    settle(1, 200);
    check(n == 2 && got_d[1] == byte_at(32'h281), "R3 resumes after kick", n, 2);

    // R10: zero length, buffer read error, then a good entry with no checksum
    do_reset(32'hC0);
    put_desc(32'hC0, 16'h8800, 16'd0, 32'h200);
    put_desc(32'hC8, 16'h8C00, 16'd2, 32'h204);
    put_desc(32'hD0, 16'hA800, 16'd1, 32'h210);
    err_en = 1'b1; err_addr = 32'h204;
    do_kick();
    settle(1, 400);
    err_en = 1'b0;
    check(err_cnt == 2 && frm_cnt == 1, "R10 error pulses", err_cnt, 2);
    check(!mem[48][31] && !mem[50][31] && !mem[52][31], "R10 aborted entries released",
          {mem[48][31], mem[50][31], mem[52][31]}, 0);
    check(n == 1 && got_e[0] && got_c[0] == 2'd0 && got_d[0] == byte_at(32'h210),
          "R6 no checksum mode", got_c[0], 0);

    // R11: descriptor fetch error
    do_reset(32'hE0);
    put_desc(32'hE0, 16'hA800, 16'd1, 32'h220);
    err_en = 1'b1; err_addr = 32'hE4;
    do_kick();
    repeat (40) @(negedge clk);
    check(err_cnt == 1 && wb_cnt == 0 && n == 0, "R11 stop without write-back", err_cnt, 1);
    err_en = 1'b0;
    do_kick();
    settle(1, 200);
    check(n == 1 && frm_cnt == 1 && !mem[56][31], "R11 retry succeeds", n, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule